// File: doc/BRIEF.md
# SDRAM Data-Path Timing Unit

This block is the data-side half of a synchronous DRAM controller. The command sequencer issues READ, WRITE, BURST STOP and PRECHARGE strobes, together with the per-lane data mask. This unit then works out, clock by clock, when the controller must drive the data pins, which write lanes are enabled, and when returned read data should be captured. Write data and the write mask act in the clock of the command itself. Read capture, the read mask and the bus-release prediction all trail the command by the programmed CAS latency, or by the fixed two-clock mask delay.

The strobes are single-cycle, per-clock controls and cannot be stalled. For that reason the block has no valid/ready pairs and no back-pressure. A strobe asserted in a cycle takes effect in that cycle, whether or not the surrounding logic is ready. CAS latency, burst-length code and single-write mode are expected to change only while no burst is in flight.

Top module: `sdram_dpath`

## Requirements
- R1: A READ in cycle n raises `rd_capture` in cycles n+CL through n+CL+BL-1. CL is `cas_lat`, with values 2 or 3 accepted. BL is 2 to the power of `bl_code`: code 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R2: A WRITE in cycle n raises `dq_oe` in cycles n through n+BL-1, starting in the same cycle as the command.
- R3: While `single_wr` is 1, a WRITE drives exactly one beat (cycle n only), whatever BL is.
- R4: In any cycle, `wr_lane_en[i]` equals `dq_oe` with lane i masked off by `dqm[i]` of that same cycle.
- R5: In any cycle, `rd_lane_en[i]` equals `rd_capture` with lane i masked off by `dqm[i]` sampled two cycles earlier.
- R6: A BURST STOP, PRECHARGE or WRITE in cycle b leaves read beats in cycles up to b+CL-1 untouched, and forces `rd_capture` low from cycle b+CL onward.
- R7: A READ issued during a read burst replaces it. Old beats end at r+CL-1 and the new burst starts at r+CL.
- R8: A READ, BURST STOP or PRECHARGE ends a write burst in its own cycle, so `dq_oe` is low in that cycle.
- R9: `rd_release` pulses high for one cycle in the first cycle after a capture window closes. This is the cycle in which the device bus returns to high impedance.
- R10: `clash` is high in every cycle where `dq_oe` and `rd_capture` are both high.
- R11: While `rst_n` is low and no strobe is asserted, every output is 0.
- R12: When several strobes arrive in one cycle, WRITE takes priority over READ, and READ takes priority over BURST STOP and PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cas_lat | input | CL_W | CAS latency, 2 or 3 |
| bl_code | input | BL_CODE_W | Burst length code, BL = 2**code |
| single_wr | input | 1 | Writes transfer one beat only |
| wr_cmd | input | 1 | WRITE strobe |
| rd_cmd | input | 1 | READ strobe |
| stop_cmd | input | 1 | BURST STOP strobe |
| pre_cmd | input | 1 | PRECHARGE strobe |
| dqm | input | MASK_W | Per-lane data mask |
| dq_oe | output | 1 | Controller drives the data pins this cycle |
| wr_lane_en | output | MASK_W | Write lanes carrying valid data |
| rd_capture | output | 1 | Read data arrives this cycle |
| rd_lane_en | output | MASK_W | Read lanes to capture |
| rd_release | output | 1 | Device bus just returned to high impedance |
| clash | output | 1 | Write beat overlaps arriving read data |

## Verification
Suppose the read event line holds a stale or misplaced entry. Then `rd_capture` opens or closes one or more cycles off the position set by CL. That shows at the ports exactly CL cycles after the offending command, and `rd_release` moves along with it. A burst counter that is not cleared by a stop or by a new command keeps `dq_oe` or `rd_capture` high past the cycle in which it should fall, so the error appears on the first beat after the interruption. A mask delay of the wrong depth gates the wrong read lane in the first cycle where `dqm` changes during a read.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_HALT  = 2'd3
  } op_e;

  // Priority: write over read over stop/precharge (R12)
  function automatic op_e decode_op(input logic wr, input logic rd,
                                    input logic st, input logic pr);
    if (wr)      return OP_WRITE;
    if (rd)      return OP_READ;
    if (st | pr) return OP_HALT;
    return OP_IDLE;
  endfunction

endpackage

// File: rtl/sdp_tap_line.sv
module sdp_tap_line #(
  parameter int W     = 4,
  parameter int DEPTH = 3,
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     d,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     q
);

  // taps[k] holds the input from k+1 cycles ago
  logic [DEPTH-1:0][W-1:0] taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps <= '0;
    end else begin
      taps[0] <= d;
      for (int k = 1; k < DEPTH; k++) taps[k] <= taps[k-1];
    end
  end

  assign q = taps[sel];

endmodule

// File: rtl/sdp_burst_span.sv
module sdp_burst_span #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             kill,
  input  logic [LEN_W-1:0] len_m1,
  output logic             active
);

  logic [LEN_W-1:0] left_q;
  logic             more;

  assign more   = (left_q != '0);
  assign active = start | (more & ~kill);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     left_q <= '0;
    else if (start) left_q <= len_m1;
    else if (kill)  left_q <= '0;
    else if (more)  left_q <= left_q - LEN_W'(1);
  end

endmodule

// File: rtl/sdram_dpath.sv
module sdram_dpath #(
  parameter int MASK_W    = 2,
  parameter int MAX_CL    = 3,
  parameter int CL_W      = 2,
  parameter int BL_CODE_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CL_W-1:0]      cas_lat,
  input  logic [BL_CODE_W-1:0] bl_code,
  input  logic                 single_wr,
  input  logic                 wr_cmd,
  input  logic                 rd_cmd,
  input  logic                 stop_cmd,
  input  logic                 pre_cmd,
  input  logic [MASK_W-1:0]    dqm,
  output logic                 dq_oe,
  output logic [MASK_W-1:0]    wr_lane_en,
  output logic                 rd_capture,
  output logic [MASK_W-1:0]    rd_lane_en,
  output logic                 rd_release,
  output logic                 clash
);
  import sdp_pkg::*;

  localparam int LEN_W    = (1 << BL_CODE_W) - 1;
  localparam int EVT_W    = 2 + LEN_W;
  localparam int MASK_LAT = 2;
  localparam int CL_SEL_W = (MAX_CL > 1) ? $clog2(MAX_CL) : 1;
  localparam int MK_SEL_W = (MASK_LAT > 1) ? $clog2(MASK_LAT) : 1;

  op_e              op;
  logic [LEN_W-1:0] len_m1;
  logic [LEN_W-1:0] wr_len;
  logic [CL_W-1:0]  cl_eff;
  logic [EVT_W-1:0] evt_in;
  logic [EVT_W-1:0] evt_due;
  logic [MASK_W-1:0] dqm_late;
  logic             rd_cap_q;

  assign op     = decode_op(wr_cmd, rd_cmd, stop_cmd, pre_cmd);
  assign len_m1 = LEN_W'((32'd1 << bl_code) - 32'd1);
  assign wr_len = single_wr ? '0 : len_m1;

  always_comb begin
    if (cas_lat < CL_W'(2))           cl_eff = CL_W'(2);
    else if (cas_lat > CL_W'(MAX_CL)) cl_eff = CL_W'(MAX_CL);
    else                              cl_eff = cas_lat;
  end

  // write side: zero latency
  sdp_burst_span #(.LEN_W(LEN_W)) i_wr_span (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (op == OP_WRITE),
    .kill   (op == OP_READ || op == OP_HALT),
    .len_m1 (wr_len),
    .active (dq_oe)
  );

  // read side: events travel CL cycles before acting
  assign evt_in = {op == OP_READ, op == OP_WRITE || op == OP_HALT, len_m1};

  sdp_tap_line #(.W(EVT_W), .DEPTH(MAX_CL)) i_evt_line (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (evt_in),
    .sel   (CL_SEL_W'(cl_eff - CL_W'(1))),
    .q     (evt_due)
  );

  sdp_burst_span #(.LEN_W(LEN_W)) i_rd_span (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (evt_due[EVT_W-1]),
    .kill   (evt_due[EVT_W-2]),
    .len_m1 (evt_due[LEN_W-1:0]),
    .active (rd_capture)
  );

  // read mask trails by a fixed two clocks
  sdp_tap_line #(.W(MASK_W), .DEPTH(MASK_LAT)) i_mask_line (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (dqm),
    .sel   (MK_SEL_W'(MASK_LAT - 1)),
    .q     (dqm_late)
  );

  for (genvar i = 0; i < MASK_W; i++) begin : g_lane
    assign wr_lane_en[i] = dq_oe      & ~dqm[i];
    assign rd_lane_en[i] = rd_capture & ~dqm_late[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_cap_q <= 1'b0;
    else        rd_cap_q <= rd_capture;
  end

  assign rd_release = rd_cap_q & ~rd_capture;
  assign clash      = dq_oe & rd_capture;

endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
  parameter int MASK_W = 2,
  parameter int CL_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CL_W-1:0]   cas_lat,
  input logic              single_wr,
  input logic              wr_cmd,
  input logic              rd_cmd,
  input logic              stop_cmd,
  input logic              pre_cmd,
  input logic [MASK_W-1:0] dqm,
  input logic              dq_oe,
  input logic [MASK_W-1:0] wr_lane_en,
  input logic              rd_capture,
  input logic [MASK_W-1:0] rd_lane_en,
  input logic              rd_release
);

  assert_wr_same_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |-> dq_oe);

  assert_single_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (single_wr && wr_cmd) |=> (dq_oe == wr_cmd));

  assert_wr_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lane_en & dqm) == '0);

  assert_rd_lat2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == CL_W'(2) && rd_cmd && !wr_cmd) |-> ##2 (rd_capture || cas_lat != CL_W'(2)));

  assert_rd_lat3_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == CL_W'(3) && rd_cmd && !wr_cmd) |-> ##3 (rd_capture || cas_lat != CL_W'(3)));

  assert_rd_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dqm != '0) |-> ##2 ((rd_lane_en & $past(dqm, 2)) == '0));

  assert_stop_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stop_cmd || pre_cmd) && !wr_cmd && !rd_cmd && cas_lat == CL_W'(2))
      |-> ##2 (!rd_capture || cas_lat != CL_W'(2)));

  assert_read_ends_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && !wr_cmd) |-> !dq_oe);

  assert_release_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_release |=> !rd_release);

endmodule

bind sdram_dpath sdp_checker #(.MASK_W(MASK_W), .CL_W(CL_W)) i_sdp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cas_lat    (cas_lat),
  .single_wr  (single_wr),
  .wr_cmd     (wr_cmd),
  .rd_cmd     (rd_cmd),
  .stop_cmd   (stop_cmd),
  .pre_cmd    (pre_cmd),
  .dqm        (dqm),
  .dq_oe      (dq_oe),
  .wr_lane_en (wr_lane_en),
  .rd_capture (rd_capture),
  .rd_lane_en (rd_lane_en),
  .rd_release (rd_release)
);

// File: tb/test_sdram_dpath.sv
module test_sdram_dpath;

  localparam int CLK_PERIOD = 10;
  localparam int MW         = 2;
  localparam int HORIZON    = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cas_lat = 2'd2;
  logic [1:0]    bl_code = 2'd2;
  logic          single_wr = 1'b0;
  logic          wr_cmd = 1'b0, rd_cmd = 1'b0, stop_cmd = 1'b0, pre_cmd = 1'b0;
  logic [MW-1:0] dqm = '0;
  logic          dq_oe, rd_capture, rd_release, clash;
  logic [MW-1:0] wr_lane_en, rd_lane_en;

  int checks = 0;
  int fails  = 0;
  int t      = 0;

  bit          m_wr  [HORIZON];
  bit          m_cap [HORIZON];
  bit [MW-1:0] m_dqm [HORIZON];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_dpath #(.MASK_W(MW)) i_sdram_dpath (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .bl_code(bl_code),
    .single_wr(single_wr), .wr_cmd(wr_cmd), .rd_cmd(rd_cmd),
    .stop_cmd(stop_cmd), .pre_cmd(pre_cmd), .dqm(dqm), .dq_oe(dq_oe),
    .wr_lane_en(wr_lane_en), .rd_capture(rd_capture), .rd_lane_en(rd_lane_en),
    .rd_release(rd_release), .clash(clash)
  );

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) cycle %0d: actual=%0h expected=%0h", req, tag, t, act, exp);
    end
  endtask

  // one clock: drive strobes, advance the model, compare every output
  task automatic cyc(input bit w, input bit r, input bit s, input bit p,
                     input bit [MW-1:0] dq, input string tag);
    int cl, nbl, nwr;
    bit e_oe, e_cap, e_rel;
    bit [MW-1:0] e_wl, e_rl, d2;
    wr_cmd = w; rd_cmd = r; stop_cmd = s; pre_cmd = p; dqm = dq;
    cl  = int'(cas_lat);
    nbl = 1 << bl_code;
    nwr = single_wr ? 1 : nbl;
    m_dqm[t] = dq;
    if (w) begin
      for (int j = t; j < t + 9; j++) m_wr[j] = 1'b0;
      for (int k = 0; k < nwr; k++) m_wr[t+k] = 1'b1;
    end else if (r || s || p) begin
      for (int j = t; j < t + 9; j++) m_wr[j] = 1'b0;
    end
    if (w || r || s || p)
      for (int j = t + cl; j < t + cl + 9; j++) m_cap[j] = 1'b0;
    if (r && !w)
      for (int k = 0; k < nbl; k++) m_cap[t+cl+k] = 1'b1;
    #(CLK_PERIOD/4);
    e_oe  = m_wr[t];
    e_cap = m_cap[t];
    d2    = (t >= 2) ? m_dqm[t-2] : '0;
    e_wl  = e_oe  ? ~dq : '0;
    e_rl  = e_cap ? ~d2 : '0;
    e_rel = (t >= 1) && m_cap[t-1] && !e_cap;
    check("R2 dq_oe",      8'(dq_oe),      8'(e_oe),          tag);
    check("R4 wr_lane_en", 8'(wr_lane_en), 8'(e_wl),          tag);
    check("R1 rd_capture", 8'(rd_capture), 8'(e_cap),         tag);
    check("R5 rd_lane_en", 8'(rd_lane_en), 8'(e_rl),          tag);
    check("R9 rd_release", 8'(rd_release), 8'(e_rel),         tag);
    check("R10 clash",     8'(clash),      8'(e_oe && e_cap), tag);
    @(negedge clk);
    t++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, '0, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 dq_oe",      8'(dq_oe),      8'h0, "R11 reset");
    check("R11 wr_lane_en", 8'(wr_lane_en), 8'h0, "R11 reset");
    check("R11 rd_capture", 8'(rd_capture), 8'h0, "R11 reset");
    check("R11 rd_lane_en", 8'(rd_lane_en), 8'h0, "R11 reset");
    check("R11 rd_release", 8'(rd_release), 8'h0, "R11 reset");
    check("R11 clash",      8'(clash),      8'h0, "R11 reset");
    rst_n = 1'b1;
    idle(2, "R11 idle");

    // R1: CL2, BL4 read with quiet mask
    cyc(0, 1, 0, 0, '0, "R1 cl2 read");
    idle(7, "R1 cl2 read");

    // R5: read mask two clocks late, changing per lane
    cyc(0, 1, 0, 0, 2'b01, "R5 mask");
    cyc(0, 0, 0, 0, 2'b10, "R5 mask");
    cyc(0, 0, 0, 0, 2'b11, "R5 mask");
    cyc(0, 0, 0, 0, 2'b00, "R5 mask");
    cyc(0, 0, 0, 0, 2'b01, "R5 mask");
    idle(5, "R5 mask");

    // R2, R4: BL4 write with a moving mask
    cyc(1, 0, 0, 0, 2'b10, "R2 write");
    cyc(0, 0, 0, 0, 2'b00, "R4 write");
    cyc(0, 0, 0, 0, 2'b11, "R4 write");
    cyc(0, 0, 0, 0, 2'b01, "R4 write");
    idle(3, "R2 write");

    // R3: single write ignores BL
    single_wr = 1'b1;
    cyc(1, 0, 0, 0, '0, "R3 single");
    idle(4, "R3 single");
    single_wr = 1'b0;

    // R6: burst stop and precharge during CL2 read
    cyc(0, 1, 0, 0, '0, "R6 stop cl2");
    cyc(0, 0, 1, 0, '0, "R6 stop cl2");
    idle(6, "R6 stop cl2");
    cyc(0, 1, 0, 0, '0, "R6 pre cl2");
    idle(2, "R6 pre cl2");
    cyc(0, 0, 0, 1, '0, "R6 pre cl2");
    idle(6, "R6 pre cl2");

    // R7: read interrupts read
    cyc(0, 1, 0, 0, '0, "R7 rd rd");
    idle(1, "R7 rd rd");
    cyc(0, 1, 0, 0, '0, "R7 rd rd");
    idle(8, "R7 rd rd");

    // R8: read, stop, precharge cut a write burst
    cyc(1, 0, 0, 0, '0, "R8 wr cut");
    cyc(0, 1, 0, 0, '0, "R8 wr cut");
    idle(6, "R8 wr cut");
    cyc(1, 0, 0, 0, '0, "R8 wr cut");
    cyc(0, 0, 1, 0, '0, "R8 wr cut");
    cyc(1, 0, 0, 0, '0, "R8 wr cut");
    idle(1, "R8 wr cut");
    cyc(0, 0, 0, 1, '0, "R8 wr cut");
    idle(3, "R8 wr cut");

    // R10: write right after read overlaps arriving data
    cyc(0, 1, 0, 0, '0, "R10 clash");
    cyc(1, 0, 0, 0, '0, "R10 clash");
    idle(7, "R10 clash");

    // R12: simultaneous strobes
    cyc(1, 1, 0, 0, '0, "R12 prio");
    idle(6, "R12 prio");
    cyc(0, 1, 1, 1, '0, "R12 prio");
    idle(7, "R12 prio");

    // CL3 with other burst lengths
    cas_lat = 2'd3;
    for (int c = 0; c < 4; c++) begin
      bl_code = 2'(c);
      cyc(0, 1, 0, 0, 2'b01, "R1 cl3");
      idle(12, "R1 cl3");
    end
    bl_code = 2'd3;
    cyc(0, 1, 0, 0, '0, "R6 stop cl3");
    idle(1, "R6 stop cl3");
    cyc(0, 0, 1, 0, '0, "R6 stop cl3");
    idle(7, "R6 stop cl3");
    cyc(0, 1, 0, 0, '0, "R6 pre cl3");
    cyc(0, 0, 0, 1, '0, "R6 pre cl3");
    idle(7, "R6 pre cl3");
    cyc(0, 1, 0, 0, '0, "R7 cl3");
    idle(2, "R7 cl3");
    cyc(0, 1, 0, 0, 2'b10, "R7 cl3");
    idle(12, "R7 cl3");
    cyc(0, 1, 0, 0, '0, "R10 cl3");
    idle(1, "R10 cl3");
    cyc(1, 0, 0, 0, '0, "R10 cl3");
    idle(12, "R10 cl3");

    summary();
    $finish;
  end

endmodule